// File: doc/BRIEF.md
# Configuration-Load Capability Register Block

This block is the register front end that lets a host stream a new core-logic image into a device across its PCIe endpoint. It sits in the endpoint's configuration space as a vendor-specific extended capability. It decodes 32-bit configuration reads and writes aimed at its window. It also watches the memory-mapped requests that the endpoint's base address registers (BARs) accept.

Outside a load session, every memory request is passed unchanged to the user application. When the host sets the session bit in the control register, the block takes over all BAR traffic. Any captured write is then treated as an image word. Any captured read returns the status word. Each image word is held in a one-word stage and offered to the downstream programming controller over a valid/ready handshake. The status register tells the host when it may send the next word. It also flags a sticky error on overflow or on a controller fault, and echoes the encryption, compression and session settings.

A control write can put the device back into load mode at any time, including while the user image is running.

Top module: `cfgld_cap_if`

## Requirements
- R1: Within the capability window (dword offsets from CAP_BASE), offset 0 reads the header `{NEXT_PTR, CAP_VER, CAP_ID}`, offset 1 reads `{length in bytes = 28 (12 bits), REV (4 bits), VSEC_ID (16 bits)}`, and offset 5 reads SILICON_ID. Writes to these three offsets have no effect.
- R2: Offset 6 holds a 16-bit board ID that resets to USER_ID. A write stores data bits 15:0, and bits 31:16 read as zero.
- R3: The control register sits at offset 3. Bit 0 is the session bit, bit 1 is encryption enable and bit 2 is compression enable. Other bits read zero. Setting bit 0 enters load mode and clearing it leaves load mode. The status register mirrors these as bit 4 (session), bit 2 (encryption) and bit 3 (compression).
- R4: In a session, an image word is a configuration write to offset 4 or any captured memory write. The word raises prog_valid on the next cycle. prog_data holds that word, unchanged, until a clock edge at which prog_ready is high.
- R5: Status bit 0 (ready to send) is high exactly when a session is active and the holding stage is empty.
- R6: An image word that arrives while ready-to-send is low is dropped, and it sets the sticky error bit, status bit 1.
- R7: A prog_err pulse sets status bit 1.
- R8: Writing 1 to status bit 1 clears the error. All other status bits ignore writes. A set in the same cycle wins over the clear.
- R9: Outside a session, every memory request appears on the usr_* outputs in the same cycle. During a session, usr_valid stays low, and a captured read returns the status word.
- R10: A configuration write to offset 4 outside a session is ignored and raises no prog_valid.
- R11: Every configuration read, and every captured read, gets rsp_valid exactly one cycle later. Writes and forwarded requests get none.
- R12: Configuration reads outside the seven-word window return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_is_cfg | input | 1 | 1 = configuration access, 0 = BAR memory access |
| req_bar | input | BAR_W | BAR that matched a memory access |
| req_addr | input | ADDR_W | Dword address (configuration space or BAR offset) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| usr_valid | output | 1 | Memory request forwarded to user logic |
| usr_write | output | 1 | Forwarded write flag |
| usr_bar | output | BAR_W | Forwarded BAR number |
| usr_addr | output | ADDR_W | Forwarded address |
| usr_wdata | output | 32 | Forwarded write data |
| prog_valid | output | 1 | Image word offered to the controller |
| prog_data | output | 32 | Image word |
| prog_ready | input | 1 | Controller accepts the word |
| prog_err | input | 1 | Controller fault pulse |
| load_active | output | 1 | Load session active |

## Verification
A corrupted session bit shows at once on the ports: usr_valid either leaks BAR traffic during a load or swallows it afterwards, in the same cycle as the request. A wrong holding-stage state shows one cycle after an image word, as prog_valid or prog_data disagreeing with the word sent. It also shows on the next status read, as a ready-to-send bit that disagrees with prog_valid. An error bit that is set or cleared wrongly stays that way, so the next status read after the faulty event exposes it.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
   localparam int NREG  = 7;
   localparam int IDX_W = 3;

   // register index inside the capability window
   localparam logic [IDX_W-1:0] RI_HDR  = 3'd0;
   localparam logic [IDX_W-1:0] RI_LEN  = 3'd1;
   localparam logic [IDX_W-1:0] RI_STAT = 3'd2;
   localparam logic [IDX_W-1:0] RI_CTRL = 3'd3;
   localparam logic [IDX_W-1:0] RI_DATA = 3'd4;
   localparam logic [IDX_W-1:0] RI_SID  = 3'd5;
   localparam logic [IDX_W-1:0] RI_UID  = 3'd6;

   // status bits
   localparam int ST_RTS = 0;
   localparam int ST_ERR = 1;
   localparam int ST_ENC = 2;
   localparam int ST_CMP = 3;
   localparam int ST_SES = 4;

   // control bits
   localparam int CT_SES = 0;
   localparam int CT_ENC = 1;
   localparam int CT_CMP = 2;
endpackage

// File: rtl/cfgld_bar_route.sv
module cfgld_bar_route (
   input  logic req_valid,
   input  logic req_write,
   input  logic req_is_cfg,
   input  logic session,
   output logic usr_valid,
   output logic cap_wr,
   output logic cap_rd
);
   logic mem_req;

   always_comb begin
      mem_req   = req_valid & ~req_is_cfg;
      usr_valid = mem_req & ~session;
      cap_wr    = mem_req & session & req_write;
      cap_rd    = mem_req & session & ~req_write;
   end
endmodule

// File: rtl/cfgld_word_fwd.sv
module cfgld_word_fwd #(
   parameter int DW   = 32,
   parameter bit HOLD = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          prog_ready,
   output logic          prog_valid,
   output logic [DW-1:0] prog_data,
   output logic          can_take,
   output logic          ovf
);
   generate
      if (HOLD) begin : g_hold
         logic          full_q;
         logic [DW-1:0] data_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               full_q <= 1'b0;
               data_q <= '0;
            end else if (wr_en && !full_q) begin
               full_q <= 1'b1;
               data_q <= wr_data;
            end else if (full_q && prog_ready) begin
               full_q <= 1'b0;
            end
         end

         always_comb begin
            prog_valid = full_q;
            prog_data  = data_q;
            can_take   = ~full_q;
            ovf        = wr_en & full_q;
         end
      end else begin : g_pass
         always_comb begin
            prog_valid = wr_en;
            prog_data  = wr_data;
            can_take   = prog_ready;
            ovf        = wr_en & ~prog_ready;
         end
      end
   endgenerate
endmodule

// File: rtl/cfgld_regs.sv
module cfgld_regs
   import cfgld_pkg::*;
#(
   parameter logic [31:0] HDR_WORD = 32'h0,
   parameter logic [31:0] LEN_WORD = 32'h0,
   parameter logic [31:0] SID_WORD = 32'h0,
   parameter logic [15:0] UID_RST  = 16'h0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic             cfg_rd,
   input  logic             in_cap,
   input  logic [IDX_W-1:0] idx,
   input  logic [15:0]      wdata,
   input  logic             cap_rd,
   input  logic             err_set,
   input  logic             can_take,
   output logic [2:0]       ctrl_q,
   output logic             st_rts,
   output logic             err_q,
   output logic             stat_clr,
   output logic             rsp_valid,
   output logic [31:0]      rsp_rdata
);
   logic [15:0] uid_q;
   logic [15:0] status;
   logic [31:0] rd_word;
   logic        wr_ctrl, wr_uid;

   always_comb begin
      wr_ctrl  = cfg_wr & in_cap & (idx == RI_CTRL);
      wr_uid   = cfg_wr & in_cap & (idx == RI_UID);
      stat_clr = cfg_wr & in_cap & (idx == RI_STAT) & wdata[ST_ERR];
      st_rts   = ctrl_q[CT_SES] & can_take;
      status         = '0;
      status[ST_RTS] = st_rts;
      status[ST_ERR] = err_q;
      status[ST_ENC] = ctrl_q[CT_ENC];
      status[ST_CMP] = ctrl_q[CT_CMP];
      status[ST_SES] = ctrl_q[CT_SES];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         uid_q  <= UID_RST;
         err_q  <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl_q <= wdata[2:0];
         if (wr_uid)  uid_q  <= wdata;
         if (err_set)       err_q <= 1'b1;
         else if (stat_clr) err_q <= 1'b0;
      end
   end

   always_comb begin
      rd_word = '0;
      if (cap_rd) begin
         rd_word = {16'h0, status};
      end else if (in_cap) begin
         case (idx)
            RI_HDR:  rd_word = HDR_WORD;
            RI_LEN:  rd_word = LEN_WORD;
            RI_STAT: rd_word = {16'h0, status};
            RI_CTRL: rd_word = {29'h0, ctrl_q};
            RI_SID:  rd_word = SID_WORD;
            RI_UID:  rd_word = {16'h0, uid_q};
            default: rd_word = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= cfg_rd | cap_rd;
         rsp_rdata <= rd_word;
      end
   end
endmodule

// File: rtl/cfgld_cap_if.sv
module cfgld_cap_if
   import cfgld_pkg::*;
#(
   parameter int          ADDR_W     = 10,
   parameter int          BAR_N      = 6,
   parameter int          CAP_BASE   = 'h040,
   parameter logic [15:0] CAP_ID     = 16'h000B,
   parameter logic [3:0]  CAP_VER    = 4'h1,
   parameter logic [11:0] NEXT_PTR   = 12'h000,
   parameter logic [15:0] VSEC_ID    = 16'h0D1A,
   parameter logic [3:0]  VSEC_REV   = 4'h1,
   parameter logic [31:0] SILICON_ID = 32'h5A17_C0DE,
   parameter logic [15:0] USER_ID    = 16'h00A5,
   parameter bit          HOLD       = 1'b1,
   localparam int         BAR_W      = (BAR_N > 1) ? $clog2(BAR_N) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_is_cfg,
   input  logic [BAR_W-1:0]  req_bar,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   output logic              rsp_valid,
   output logic [31:0]       rsp_rdata,
   output logic              usr_valid,
   output logic              usr_write,
   output logic [BAR_W-1:0]  usr_bar,
   output logic [ADDR_W-1:0] usr_addr,
   output logic [31:0]       usr_wdata,
   output logic              prog_valid,
   output logic [31:0]       prog_data,
   input  logic              prog_ready,
   input  logic              prog_err,
   output logic              load_active
);
   localparam logic [ADDR_W-1:0] BASE_A   = ADDR_W'(CAP_BASE);
   localparam logic [11:0]       LEN_B    = 12'(NREG * 4);
   localparam logic [31:0]       HDR_WORD = {NEXT_PTR, CAP_VER, CAP_ID};
   localparam logic [31:0]       LEN_WORD = {LEN_B, VSEC_REV, VSEC_ID};

   initial begin
      assert (ADDR_W >= IDX_W + 1) else $error("ADDR_W too small");
      assert (CAP_BASE + NREG <= (1 << ADDR_W)) else $error("window outside address space");
      assert (BAR_N >= 1) else $error("BAR_N must be at least 1");
   end

   logic [ADDR_W-1:0] cfg_off;
   logic              in_cap, cfg_wr, cfg_rd, data_wr;
   logic              cap_wr, cap_rd, can_take, ovf;
   logic              st_rts, err_q, stat_clr;
   logic [2:0]        ctrl_q;
   logic [IDX_W-1:0]  idx;

   always_comb begin
      cfg_off = req_addr - BASE_A;
      in_cap  = (req_addr >= BASE_A) && (cfg_off < ADDR_W'(NREG));
      idx     = cfg_off[IDX_W-1:0];
      cfg_wr  = req_valid & req_is_cfg & req_write;
      cfg_rd  = req_valid & req_is_cfg & ~req_write;
      data_wr = load_active & ((cfg_wr & in_cap & (idx == RI_DATA)) | cap_wr);
      load_active = ctrl_q[CT_SES];
      usr_write = req_write;
      usr_bar   = req_bar;
      usr_addr  = req_addr;
      usr_wdata = req_wdata;
   end

   cfgld_bar_route i_route (
      .req_valid  (req_valid),
      .req_write  (req_write),
      .req_is_cfg (req_is_cfg),
      .session    (load_active),
      .usr_valid  (usr_valid),
      .cap_wr     (cap_wr),
      .cap_rd     (cap_rd)
   );

   cfgld_word_fwd #(.DW(32), .HOLD(HOLD)) i_fwd (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (data_wr),
      .wr_data    (req_wdata),
      .prog_ready (prog_ready),
      .prog_valid (prog_valid),
      .prog_data  (prog_data),
      .can_take   (can_take),
      .ovf        (ovf)
   );

   cfgld_regs #(
      .HDR_WORD (HDR_WORD),
      .LEN_WORD (LEN_WORD),
      .SID_WORD (SILICON_ID),
      .UID_RST  (USER_ID)
   ) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (cfg_wr),
      .cfg_rd    (cfg_rd),
      .in_cap    (in_cap),
      .idx       (idx),
      .wdata     (req_wdata[15:0]),
      .cap_rd    (cap_rd),
      .err_set   (ovf | prog_err),
      .can_take  (can_take),
      .ctrl_q    (ctrl_q),
      .st_rts    (st_rts),
      .err_q     (err_q),
      .stat_clr  (stat_clr),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata)
   );
endmodule

// File: rtl/cfgld_cap_if_chk.sv
module cfgld_cap_if_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic        req_write,
   input logic        req_is_cfg,
   input logic        rsp_valid,
   input logic        usr_valid,
   input logic        prog_valid,
   input logic [31:0] prog_data,
   input logic        prog_ready,
   input logic        load_active,
   input logic        data_wr,
   input logic        st_rts,
   input logic        err_q,
   input logic        stat_clr
);
   // R4
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prog_valid && !prog_ready |=> prog_valid && $stable(prog_data));

   // R5
   rts_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prog_valid |-> !st_rts);

   // R6
   overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_wr && prog_valid |=> err_q);

   // R8
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_q && !stat_clr |=> err_q);

   // R9
   route_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_active |-> !usr_valid);

   // R11
   rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid && !req_write && (req_is_cfg || load_active)));
endmodule

bind cfgld_cap_if cfgld_cap_if_chk i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_write   (req_write),
   .req_is_cfg  (req_is_cfg),
   .rsp_valid   (rsp_valid),
   .usr_valid   (usr_valid),
   .prog_valid  (prog_valid),
   .prog_data   (prog_data),
   .prog_ready  (prog_ready),
   .load_active (load_active),
   .data_wr     (data_wr),
   .st_rts      (st_rts),
   .err_q       (err_q),
   .stat_clr    (stat_clr)
);

// File: tb/test_cfgld_cap_if.sv
module test_cfgld_cap_if;
   localparam int CLK_P = 10;
   localparam logic [9:0] B = 10'h040;
   localparam logic [31:0] HDR = 32'h0001_000B;
   localparam logic [31:0] LENW = 32'h01C1_0D1A;
   localparam logic [31:0] SID = 32'h5A17_C0DE;

   typedef struct packed {
      logic [7:0]  rq;
      logic        wr;
      logic [9:0]  addr;
      logic [31:0] wd;
      logic [31:0] ex;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{8'd1,  1'b0, B + 10'd0, 32'h0,         HDR},          // R1
      '{8'd1,  1'b1, B + 10'd0, 32'hFFFF_FFFF, HDR},          // R1
      '{8'd1,  1'b1, B + 10'd1, 32'h0,         LENW},         // R1
      '{8'd1,  1'b1, B + 10'd5, 32'h0,         SID},          // R1
      '{8'd2,  1'b0, B + 10'd6, 32'h0,         32'h0000_00A5},// R2
      '{8'd2,  1'b1, B + 10'd6, 32'hFFFF_1234, 32'h0000_1234},// R2
      '{8'd3,  1'b1, B + 10'd3, 32'hFFFF_FFF6, 32'h0000_0006},// R3
      '{8'd3,  1'b0, B + 10'd2, 32'h0,         32'h0000_000C},// R3
      '{8'd3,  1'b1, B + 10'd3, 32'h0,         32'h0},        // R3
      '{8'd12, 1'b1, B + 10'd7, 32'h1234_5678, 32'h0},        // R12
      '{8'd12, 1'b0, B - 10'd1, 32'h0,         32'h0}         // R12
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0, req_is_cfg = 1'b0;
   logic [2:0]  req_bar = '0;
   logic [9:0]  req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic rsp_valid, usr_valid, usr_write, prog_valid, load_active;
   logic [31:0] rsp_rdata, usr_wdata, prog_data;
   logic [2:0]  usr_bar;
   logic [9:0]  usr_addr;
   logic prog_ready = 1'b0, prog_err = 1'b0;

   int total = 0, bad = 0;
   logic done = 1'b0;
   logic [31:0] rd;
   logic        rv;

   always #(CLK_P/2) clk = ~clk;

   cfgld_cap_if i_cfgld_cap_if (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_is_cfg(req_is_cfg), .req_bar(req_bar), .req_addr(req_addr),
      .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .usr_valid(usr_valid), .usr_write(usr_write), .usr_bar(usr_bar),
      .usr_addr(usr_addr), .usr_wdata(usr_wdata), .prog_valid(prog_valid),
      .prog_data(prog_data), .prog_ready(prog_ready), .prog_err(prog_err),
      .load_active(load_active)
   );

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
      end
   endtask

   // one request; returns after the edge that samples it
   task automatic access(input logic w, input logic cfg, input logic [9:0] a,
                         input logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = w; req_is_cfg = cfg; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      rd = rsp_rdata; rv = rsp_valid;
   endtask

   task automatic pulse_ready();
      @(negedge clk); prog_ready = 1'b1;
      @(negedge clk); prog_ready = 1'b0;
   endtask

   initial begin
      #(CLK_P * 20000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state (R3 R4 R11)
      chk("R3 load_active at reset", {31'h0, load_active}, 32'h0);
      chk("R4 prog_valid at reset", {31'h0, prog_valid}, 32'h0);
      chk("R11 rsp_valid at reset", {31'h0, rsp_valid}, 32'h0);

      // register table
      for (int i = 0; i < NV; i++) begin
         if (VECS[i].wr) access(1'b1, 1'b1, VECS[i].addr, VECS[i].wd);
         access(1'b0, 1'b1, VECS[i].addr, 32'h0);
         total++;
         if (rd !== VECS[i].ex || rv !== 1'b1) begin
            bad++;
            $display("FAIL R%0d vec %0d: actual=%h/%b expected=%h/1",
                     VECS[i].rq, i, rd, rv, VECS[i].ex);
         end
      end

      // R9 R11: forwarding outside a session
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_is_cfg = 1'b0; req_bar = 3'd2;
      req_addr = 10'h005; req_wdata = 32'hCAFE_0001;
      #1;
      chk("R9 usr_valid off-session", {31'h0, usr_valid}, 32'h1);
      chk("R9 usr_wdata", usr_wdata, 32'hCAFE_0001);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R11 no rsp for forwarded", {31'h0, rsp_valid}, 32'h0);

      // R10: data write with no session
      access(1'b1, 1'b1, B + 10'd4, 32'h1111_2222);
      chk("R10 data ignored off-session", {31'h0, prog_valid}, 32'h0);

      // R3: enter session
      access(1'b1, 1'b1, B + 10'd3, 32'h1);
      chk("R3 load_active set", {31'h0, load_active}, 32'h1);
      access(1'b0, 1'b1, B + 10'd2, 32'h0);
      chk("R5 status idle session", rd, 32'h11);

      // R4 R9: captured BAR write
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_is_cfg = 1'b0; req_bar = 3'd2;
      req_addr = 10'h005; req_wdata = 32'hAAAA_5555;
      #1;
      chk("R9 usr_valid blocked", {31'h0, usr_valid}, 32'h0);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R4 prog_valid after word", {31'h0, prog_valid}, 32'h1);
      chk("R4 prog_data", prog_data, 32'hAAAA_5555);
      chk("R11 no rsp for captured write", {31'h0, rsp_valid}, 32'h0);

      // R9 R5 R11: captured read returns status
      access(1'b0, 1'b0, 10'h010, 32'h0);
      chk("R11 captured read rsp_valid", {31'h0, rv}, 32'h1);
      chk("R5 R9 captured status busy", rd, 32'h10);

      // R6: overflow
      access(1'b1, 1'b1, B + 10'd4, 32'h1234_5678);
      chk("R6 dropped word", prog_data, 32'hAAAA_5555);
      access(1'b0, 1'b1, B + 10'd2, 32'h0);
      chk("R6 error set", rd, 32'h12);

      // R4 R5: drain
      pulse_ready();
      chk("R4 drained", {31'h0, prog_valid}, 32'h0);
      access(1'b0, 1'b1, B + 10'd2, 32'h0);
      chk("R5 R6 rts back, err sticky", rd, 32'h13);

      // R4 via config data register
      access(1'b1, 1'b1, B + 10'd4, 32'h0BAD_F00D);
      chk("R4 cfg word valid", {31'h0, prog_valid}, 32'h1);
      chk("R4 cfg word data", prog_data, 32'h0BAD_F00D);

      // R8: write-one-to-clear
      access(1'b1, 1'b1, B + 10'd2, 32'hFFFF_FFFD);
      access(1'b0, 1'b1, B + 10'd2, 32'h0);
      chk("R8 non-W1C write ignored", rd, 32'h12);
      access(1'b1, 1'b1, B + 10'd2, 32'h2);
      access(1'b0, 1'b1, B + 10'd2, 32'h0);
      chk("R8 error cleared", rd, 32'h10);

      // R7: controller fault
      @(negedge clk); prog_err = 1'b1;
      @(negedge clk); prog_err = 1'b0;
      access(1'b0, 1'b1, B + 10'd2, 32'h0);
      chk("R7 prog_err sets error", rd, 32'h12);

      // R8: set beats clear
      @(negedge clk);
      prog_err = 1'b1; req_valid = 1'b1; req_write = 1'b1; req_is_cfg = 1'b1;
      req_addr = B + 10'd2; req_wdata = 32'h2;
      @(negedge clk);
      prog_err = 1'b0; req_valid = 1'b0; req_write = 1'b0;
      access(1'b0, 1'b1, B + 10'd2, 32'h0);
      chk("R8 set wins over clear", rd, 32'h12);

      // R3 R9: leave session
      access(1'b1, 1'b1, B + 10'd3, 32'h0);
      chk("R3 load_active cleared", {31'h0, load_active}, 32'h0);
      access(1'b0, 1'b1, B + 10'd2, 32'h0);
      chk("R5 status after exit", rd, 32'h02);
      access(1'b0, 1'b0, 10'h020, 32'h0);
      chk("R11 forwarded read no rsp", {31'h0, rv}, 32'h0);
      pulse_ready();
      chk("R4 drain after exit", {31'h0, prog_valid}, 32'h0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule